// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block turns a fast system clock into the sample-enable strobe that a UART receiver's oversampling state machine advances on. The wanted strobe rate is the baud rate times the oversampling factor. With a 100 MHz clock, 115200 baud and eight samples per bit, that rate is 921600 Hz. The ideal clock-to-tick ratio is therefore about 108.51, which is not an integer.

A single fixed terminal count would make the sample points drift through a frame. The block instead uses one of two divide values for each bit period. During even bit periods every tick interval is the shorter count. During odd bit periods every tick interval is the longer count. Averaged over two bits, the rate lands within a fraction of a clock of the ideal ratio.

A second strobe marks the last tick of each bit period, so a receiver can count bits without a counter of its own. The enable input freezes the whole timebase without losing its place.

Top module: `frac_tick_gen`

## Requirements
- R1: While `rst_n` is low, `tick` and `bit_stb` are 0. After release with `en` held high, the first `tick` appears on the output in the cycle following the DIV_EVEN-th rising edge.
- R2: `tick` is high for exactly one clock and is never high on two consecutive cycles.
- R3: Within an even bit period, consecutive ticks are DIV_EVEN enabled clock edges apart (default 108). The first bit period after reset is even.
- R4: Within an odd bit period, consecutive ticks are DIV_ODD enabled clock edges apart (default 109).
- R5: `bit_stb` is high together with every OVERSAMPLE-th tick (default 8) counted from reset. At that tick the bit period switches between even and odd.
- R6: Any two consecutive bit periods contain 2×OVERSAMPLE ticks spanning OVERSAMPLE×(DIV_EVEN+DIV_ODD) enabled edges (1736 by default).
- R7: A clock edge with `en` low changes no counter, and neither strobe is high after it. The spacing therefore counts only edges at which `en` was high.
- R8: `bit_stb` is never high without `tick`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| en | input | 1 | Clock enable for the whole timebase |
| tick | output | 1 | One-cycle oversampling strobe |
| bit_stb | output | 1 | One-cycle strobe on the last tick of each bit period |

## Verification
The scoreboard predicts every tick's spacing and bit-strobe flag from its index since reset. A design that used one divide value, or that swapped the parity at the wrong tick, would miscompare at the ninth tick or at the sixteen-tick total. An irregular enable pattern catches a counter that keeps running, or a strobe that fires while the block is frozen; either one changes the measured spacing. A reset issued in the middle of a tick interval must restart in the even parity. A design that kept its parity flag or its counter across the reset would produce a wrong first gap.

// File: rtl/ftg_pkg.sv
package ftg_pkg;

  typedef enum logic {
    BIT_EVEN = 1'b0,
    BIT_ODD  = 1'b1
  } bit_parity_e;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ftg_divider.sv
module ftg_divider
  import ftg_pkg::*;
#(
  parameter int unsigned DIV_EVEN = 108,
  parameter int unsigned DIV_ODD  = 109
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en,
  input  bit_parity_e parity,
  output logic        wrap,
  output logic        tick
);

  localparam int unsigned DIV_MAX = max_u(DIV_EVEN, DIV_ODD);
  localparam int unsigned CNT_W   = $clog2(DIV_MAX);
  localparam logic [CNT_W-1:0] LAST_EVEN = CNT_W'(DIV_EVEN - 1);
  localparam logic [CNT_W-1:0] LAST_ODD  = CNT_W'(DIV_ODD - 1);
  localparam logic [CNT_W-1:0] LAST_MAX  = CNT_W'(DIV_MAX - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] last_sel;
  logic             tick_q, tick_d;

  // next-state
  always_comb begin
    last_sel = (parity == BIT_ODD) ? LAST_ODD : LAST_EVEN;
    wrap     = en && (cnt_q == last_sel);
    cnt_d    = cnt_q;
    tick_d   = 1'b0;
    if (en) begin
      if (wrap) begin
        cnt_d  = '0;
        tick_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      tick_q <= tick_d;
    end
  end

  assign tick = tick_q;

  initial begin
    assert (DIV_EVEN >= 2 && DIV_ODD >= 2)
      else $error("divide values must be at least 2");
  end

  assert_tick_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q |=> !tick_q);

  assert_hold_when_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(cnt_q) && !tick_q));

  assert_cnt_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST_MAX);

endmodule

// File: rtl/ftg_bit_phase.sv
module ftg_bit_phase
  import ftg_pkg::*;
#(
  parameter int unsigned OVERSAMPLE = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        adv,
  input  logic        tick_seen,
  output bit_parity_e parity,
  output logic        bit_stb
);

  localparam int unsigned PH_W = $clog2(OVERSAMPLE);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(OVERSAMPLE - 1);

  logic [PH_W-1:0] phase_q, phase_d;
  bit_parity_e     parity_q, parity_d;
  logic            bstb_q, bstb_d;

  // next-state
  always_comb begin
    phase_d  = phase_q;
    parity_d = parity_q;
    bstb_d   = 1'b0;
    if (adv) begin
      if (phase_q == PH_LAST) begin
        phase_d  = '0;
        bstb_d   = 1'b1;
        parity_d = (parity_q == BIT_EVEN) ? BIT_ODD : BIT_EVEN;
      end else begin
        phase_d = phase_q + 1'b1;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= '0;
      parity_q <= BIT_EVEN;
      bstb_q   <= 1'b0;
    end else begin
      phase_q  <= phase_d;
      parity_q <= parity_d;
      bstb_q   <= bstb_d;
    end
  end

  assign parity  = parity_q;
  assign bit_stb = bstb_q;

  initial begin
    assert (OVERSAMPLE >= 2 && (OVERSAMPLE & (OVERSAMPLE - 1)) == 0)
      else $error("oversampling factor must be a power of two >= 2");
  end

  assert_bit_with_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bstb_q |-> tick_seen);

  assert_parity_flip_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bstb_q |-> (parity_q != $past(parity_q)));

  assert_phase_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> ($stable(phase_q) && $stable(parity_q)));

endmodule

// File: rtl/frac_tick_gen.sv
module frac_tick_gen
  import ftg_pkg::*;
#(
  parameter int unsigned DIV_EVEN   = 108,
  parameter int unsigned DIV_ODD    = 109,
  parameter int unsigned OVERSAMPLE = 8,
  parameter bit          HAS_BIT_STB = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick,
  output logic bit_stb
);

  bit_parity_e parity;
  logic        wrap;
  logic        tick_i;
  logic        bstb_i;

  ftg_divider #(
    .DIV_EVEN (DIV_EVEN),
    .DIV_ODD  (DIV_ODD)
  ) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (en),
    .parity (parity),
    .wrap   (wrap),
    .tick   (tick_i)
  );

  ftg_bit_phase #(
    .OVERSAMPLE (OVERSAMPLE)
  ) u_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .adv       (wrap),
    .tick_seen (tick_i),
    .parity    (parity),
    .bit_stb   (bstb_i)
  );

  assign tick = tick_i;

  generate
    if (HAS_BIT_STB) begin : g_bstb
      assign bit_stb = bstb_i;
    end else begin : g_no_bstb
      assign bit_stb = 1'b0;
    end
  endgenerate

endmodule

// File: tb/frac_tick_gen_bench.sv
module frac_tick_gen_bench;

  localparam int DIV_EVEN = 108;
  localparam int DIV_ODD  = 109;
  localparam int OVS      = 8;

  typedef struct {
    int gap;
    bit bstb;
    int idx;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic tick, bit_stb;

  int vectors = 0;
  int fails = 0;
  exp_t expq[$];
  int next_k = 1;

  int edges = 0;
  int pair_acc = 0;
  bit prev_tick = 1'b0;
  bit last_en = 1'b0;

  always #5 clk = ~clk;

  frac_tick_gen u_frac_tick_gen (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .tick    (tick),
    .bit_stb (bit_stb)
  );

  // count enabled edges since the last tick
  always @(posedge clk) begin
    last_en = en;
    if (rst_n && en) edges = edges + 1;
  end

  // monitor
  always @(negedge clk) begin
    if (!rst_n) begin
      edges = 0;
      pair_acc = 0;
      prev_tick = 1'b0;
    end else begin
      if (tick && prev_tick) begin
        fails++; $display("FAIL R2: tick on consecutive cycles, actual 1 expected 0");
      end
      vectors++;
      if (bit_stb && !tick) begin
        fails++; $display("FAIL R8: bit_stb=%0d without tick=%0d, expected tick 1", bit_stb, tick);
      end
      if (!last_en) begin
        vectors++;
        if (tick || bit_stb) begin
          fails++; $display("FAIL R7: strobe after disabled edge, actual tick=%0d bstb=%0d expected 0", tick, bit_stb);
        end
      end
      if (tick) begin
        if (expq.size() == 0) begin
          vectors++; fails++;
          $display("FAIL R3: unexpected tick, actual gap %0d expected no tick", edges);
        end else begin
          exp_t e;
          e = expq.pop_front();
          vectors++;
          if (edges != e.gap) begin
            fails++;
            if (e.gap == DIV_EVEN)
              $display("FAIL R3: tick %0d gap actual %0d expected %0d", e.idx, edges, e.gap);
            else
              $display("FAIL R4: tick %0d gap actual %0d expected %0d", e.idx, edges, e.gap);
          end
          vectors++;
          if (bit_stb != e.bstb) begin
            fails++; $display("FAIL R5: tick %0d bit_stb actual %0d expected %0d", e.idx, bit_stb, e.bstb);
          end
          pair_acc += edges;
          if (e.idx % (2*OVS) == 0) begin
            vectors++;
            if (pair_acc != OVS*(DIV_EVEN+DIV_ODD)) begin
              fails++; $display("FAIL R6: two-bit span actual %0d expected %0d", pair_acc, OVS*(DIV_EVEN+DIV_ODD));
            end
            pair_acc = 0;
          end
        end
        edges = 0;
      end
      prev_tick = tick;
    end
  end

  // driver: push expected ticks
  task automatic push_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      exp_t e;
      e.idx  = next_k;
      e.gap  = (((next_k-1)/OVS) % 2 == 0) ? DIV_EVEN : DIV_ODD;
      e.bstb = (next_k % OVS == 0);
      expq.push_back(e);
      next_k++;
    end
  endtask

  task automatic drain();
    while (expq.size() != 0) @(negedge clk);
  endtask

  task automatic do_reset(input int cycles);
    @(negedge clk);
    rst_n = 1'b0;
    en = 1'b0;
    expq.delete();
    next_k = 1;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      vectors++;
      if (tick !== 1'b0 || bit_stb !== 1'b0) begin
        fails++; $display("FAIL R1: in reset tick=%0d bstb=%0d expected 0", tick, bit_stb);
      end
    end
    rst_n = 1'b1;
  endtask

  task automatic run_all();
    logic [7:0] lfsr;
    do_reset(5);
    en = 1'b1;
    push_ticks(48);          // R1 first gap, R3/R4/R5/R6 steady
    drain();

    // R7: irregular enable
    push_ticks(32);
    lfsr = 8'hA5;
    while (expq.size() != 0) begin
      @(negedge clk);
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      en = (lfsr[1:0] != 2'b00);
    end
    en = 1'b1;

    // mid-interval reset, then restart in even parity (R1)
    repeat (50) @(negedge clk);
    do_reset(3);
    en = 1'b1;
    push_ticks(20);
    drain();

    // long disable: no strobes while off (R7)
    @(negedge clk);
    en = 1'b0;
    repeat (300) @(negedge clk);
    en = 1'b1;
    push_ticks(12);
    drain();
    repeat (20) @(negedge clk);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule